// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block turns single and burst read or write requests into command sequences for a four-bank SDRAM. It runs in one of two modes selected by a configuration pin. In auto-precharge mode every access is an activate followed by a read or write that closes the row again. In bank-active mode rows are left open, and a per-bank table records which row each bank holds, so that a later access to the same row skips the precharge and activate entirely. An access to a bank holding a different row precharges that bank, activates the new row and then issues the column command.

A refresh strobe marks a refresh as pending. The pending refresh is served before any new access: open banks are closed with a precharge-all, the auto-refresh command follows, and the open-row table is emptied. Requests addressed to some other memory region are acknowledged without any SDRAM command and leave the table as it was. Activate-to-column, precharge-to-activate, write-recovery and refresh durations are programmable cycle counts; CAS latency is programmable from one to three.

The command outputs are a decode of registered state only. A request is taken in a cycle where `req_valid` and `req_ready` are both high; `acc_done` pulses when the access has fully drained, and `rd_valid` marks the cycles in which read data returns.

Top module: `sdram_row_seq`

## Requirements
- R1: After reset the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), `acc_done` and `rd_valid` are low, `req_ready` is high and `sd_dqm` is all ones.
- R2: Command encodings are ACT 0,0,1,1; READ 0,1,0,1; WRIT 0,1,0,0; PRE 0,0,1,0; REF 0,0,0,1 on cs_n,ras_n,cas_n,we_n. `sd_addr[10]` on READ/WRIT is 1 in auto-precharge mode (`cfg_bank_active`=0) and 0 in bank-active mode; the column sits in `sd_addr[COL_W-1:0]` and the bank on `sd_ba`.
- R3: In bank-active mode a write (or a read with CAS latency of two or more) to a bank whose open row equals the requested row issues WRIT/READ in the cycle after acceptance, with no PRE or ACT.
- R4: A request to a bank holding another row issues PRE to that bank (`sd_addr[10]`=0) one cycle after acceptance, ACT with the new row `cfg_trp` cycles later, and READ/WRIT `cfg_trcd` cycles after ACT.
- R5: A request to a closed bank issues ACT with the row one cycle after acceptance and READ/WRIT `cfg_trcd` cycles later; in bank-active mode the row then stays open, so a repeat of it is a hit.
- R6: A row-hit read with CAS latency one issues one NOP cycle before READ (READ two cycles after acceptance), and `sd_dqm` already carries the inverted byte enables in that NOP cycle.
- R7: A row-hit read with CAS latency two or three issues READ one cycle after acceptance, with no NOP inserted.
- R8: After a write with auto-precharge only NOP is issued for beats plus `cfg_trwl_tap` cycles; after a read with auto-precharge the drain is CAS latency plus beats plus `cfg_trp` cycles.
- R9: A refresh strobe blocks new requests (`req_ready` low from the next cycle); the sequencer then issues PRE with `sd_addr[10]`=1 if any bank is open, REF `cfg_trp` cycles later (or at once if none is open), returns to idle `cfg_trfc` cycles after REF, and afterwards every bank is closed.
- R10: A request with `req_local`=0 issues no command, pulses `acc_done` in the next cycle and leaves every open row as it was.
- R11: `rd_valid` is high for exactly one cycle (single) or BURST_LEN cycles (burst), starting CAS-latency cycles after the READ command; never for writes.
- R12: `acc_done` pulses for one cycle when the access has drained: READ/WRIT cycle plus CAS latency plus beats for reads, plus beats for writes (each plus the auto-precharge term of R8); `req_ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and no refresh pending |
| req_local | input | 1 | 1: request targets this SDRAM; 0: other region |
| req_write | input | 1 | 1: write, 0: read |
| req_burst | input | 1 | 1: BURST_LEN beats, 0: single beat |
| req_bank | input | BANK_W | Bank index |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_be | input | BE_W | Byte enables, active high |
| refresh_req | input | 1 | Refresh strobe |
| cfg_bank_active | input | 1 | 1: keep rows open, 0: auto-precharge |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_trcd | input | TIM_W | Activate-to-column cycles |
| cfg_trp | input | TIM_W | Precharge-to-next-command cycles |
| cfg_trwl_tap | input | TIM_W | Write recovery plus auto-precharge cycles |
| cfg_trfc | input | TIM_W | Refresh duration in cycles |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Row / column address, bit 10 auto-precharge |
| sd_ba | output | BANK_W | Bank select |
| sd_dqm | output | BE_W | Byte mask, active high |
| acc_done | output | 1 | Access complete pulse |
| rd_valid | output | 1 | Read data valid |

## Verification
Counting from the cycle a request is accepted as cycle 0, the first command is due in cycle 1; ACT, PRE and the column command fall at offsets built from `cfg_trp`, `cfg_trcd` and the CL-one NOP, read data is due CAS-latency cycles after READ, and `acc_done` falls at the column-command cycle plus the drain of R8/R12. The bench computes every one of these offsets arithmetically from the configuration and its own open-row model, then samples command pins, `rd_valid`, `acc_done` and `sd_dqm` on the falling edge of every cycle up to the done cycle, so that each is compared in exactly the cycle it is due and NOP is required in all others. Refresh is checked the same way from the strobe cycle, and a sweep over both modes, three CAS latencies, four banks, reads and writes, single and burst reaches idle, hit and miss paths for each.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // Command pins {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_ACT  = 4'b0011;
  localparam logic [3:0] CMD_READ = 4'b0101;
  localparam logic [3:0] CMD_WRIT = 4'b0100;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREA,
    ST_REF,
    ST_PRE,
    ST_ACT,
    ST_NOP,
    ST_RW,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/sdr_row_table.sv
module sdr_row_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              open_en,
  input  logic              close_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_hit,
  output logic              any_open
);

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel_b;
    logic open_en_b;
    logic open_n_b;

    assign sel_b     = (upd_bank == BANK_W'(g));
    assign open_en_b = clear_all | (sel_b & (open_en | close_en));
    assign open_n_b  = ~clear_all & sel_b & open_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
      end else if (open_en_b) begin
        open_q[g] <= open_n_b;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_b & open_en) begin
        row_q[g] <= upd_row;
      end
    end
  end

  assign look_open = open_q[look_bank];
  assign look_hit  = look_open & (row_q[look_bank] == look_row);
  assign any_open  = |open_q;

  // R9: a refresh leaves no bank open
  p_refresh_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (open_q == '0));

endmodule

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    if (load) begin
      cnt_n = load_val;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CNT_W'(1);
    end else begin
      cnt_n = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_rd_valid.sv
module sdr_rd_valid #(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [1:0]        cas_lat,
  input  logic [BEAT_W-1:0] beats,
  output logic              valid
);

  logic [1:0]        dly_q, dly_n;
  logic [BEAT_W-1:0] rem_q, rem_n;

  always_comb begin
    dly_n = dly_q;
    rem_n = rem_q;
    if (issue) begin
      dly_n = cas_lat - 2'd1;
      rem_n = beats;
    end else if (dly_q != 2'd0) begin
      dly_n = dly_q - 2'd1;
    end else if (rem_q != '0) begin
      rem_n = rem_q - BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= 2'd0;
      rem_q <= '0;
    end else begin
      dly_q <= dly_n;
      rem_q <= rem_n;
    end
  end

  assign valid = (dly_q == 2'd0) && (rem_q != '0);

  // R11: a new READ is only issued once the previous burst has returned
  p_issue_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (rem_q == '0));

endmodule

// File: rtl/sdram_row_seq.sv
module sdram_row_seq
  import sdr_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BE_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  parameter int TIM_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int BEAT_W   = $clog2(BURST_LEN + 1),
  localparam int CNT_W    = TIM_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_local,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BE_W-1:0]   req_be,
  input  logic              refresh_req,
  input  logic              cfg_bank_active,
  input  logic [1:0]        cfg_cas_lat,
  input  logic [TIM_W-1:0]  cfg_trcd,
  input  logic [TIM_W-1:0]  cfg_trp,
  input  logic [TIM_W-1:0]  cfg_trwl_tap,
  input  logic [TIM_W-1:0]  cfg_trfc,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic [BE_W-1:0]   sd_dqm,
  output logic              acc_done,
  output logic              rd_valid
);

  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_i_n = rs_q[1];

  // ---------------- state
  seq_state_e state_q, state_n, ret_q, ret_n;
  logic acc_q, acc_n;
  logic done_q, done_n;
  logic ref_pend_q, ref_pend_n;

  logic [BANK_W-1:0] r_bank;
  logic [ROW_W-1:0]  r_row;
  logic [COL_W-1:0]  r_col;
  logic [BE_W-1:0]   r_be;
  logic              r_wr;
  logic              r_burst;

  logic accept;
  logic ap_mode;
  logic cl_one;
  logic [BEAT_W-1:0] beats;
  logic [CNT_W-1:0]  drain;

  // table and helpers
  logic tbl_clear, tbl_open, tbl_close;
  logic look_open, look_hit, any_open;
  logic cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic rd_issue;

  assign req_ready = (state_q == ST_IDLE) && !ref_pend_q;
  assign accept    = req_valid && req_ready;
  assign ap_mode   = !cfg_bank_active;
  assign cl_one    = (cfg_cas_lat == 2'd1);
  assign beats     = r_burst ? BEAT_W'(BURST_LEN) : BEAT_W'(1);

  always_comb begin
    if (r_wr) begin
      drain = CNT_W'(beats) + (ap_mode ? CNT_W'(cfg_trwl_tap) : '0);
    end else begin
      drain = CNT_W'(cfg_cas_lat) + CNT_W'(beats) + (ap_mode ? CNT_W'(cfg_trp) : '0);
    end
  end

  // ---------------- submodules
  sdr_row_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear_all (tbl_clear),
    .open_en   (tbl_open),
    .close_en  (tbl_close),
    .upd_bank  (r_bank),
    .upd_row   (r_row),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_open (look_open),
    .look_hit  (look_hit),
    .any_open  (any_open)
  );

  sdr_wait_cnt #(
    .CNT_W (CNT_W)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  sdr_rd_valid #(
    .BEAT_W (BEAT_W)
  ) u_rdv (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .issue   (rd_issue),
    .cas_lat (cfg_cas_lat),
    .beats   (beats),
    .valid   (rd_valid)
  );

  // ---------------- next-state logic
  logic             adv;
  logic [CNT_W-1:0] spc;
  seq_state_e       tgt;

  always_comb begin
    state_n   = state_q;
    ret_n     = ret_q;
    acc_n     = acc_q;
    done_n    = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    tbl_clear = 1'b0;
    tbl_open  = 1'b0;
    tbl_close = 1'b0;
    rd_issue  = 1'b0;
    adv       = 1'b0;
    spc       = CNT_W'(1);
    tgt       = ST_IDLE;

    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_q) begin
          adv = 1'b1;
          tgt = any_open ? ST_PREA : ST_REF;
        end else if (req_valid) begin
          if (!req_local) begin
            done_n = 1'b1;
          end else begin
            acc_n = 1'b1;
            adv   = 1'b1;
            if (look_hit) begin
              tgt = (!req_write && cl_one) ? ST_NOP : ST_RW;
            end else if (look_open) begin
              tgt = ST_PRE;
            end else begin
              tgt = ST_ACT;
            end
          end
        end
      end
      ST_PREA: begin
        adv = 1'b1;
        spc = CNT_W'(cfg_trp);
        tgt = ST_REF;
      end
      ST_REF: begin
        adv       = 1'b1;
        spc       = CNT_W'(cfg_trfc);
        tgt       = ST_IDLE;
        tbl_clear = 1'b1;
      end
      ST_PRE: begin
        adv       = 1'b1;
        spc       = CNT_W'(cfg_trp);
        tgt       = ST_ACT;
        tbl_close = 1'b1;
      end
      ST_ACT: begin
        adv = 1'b1;
        spc = CNT_W'(cfg_trcd);
        tgt = ST_RW;
      end
      ST_NOP: begin
        adv = 1'b1;
        tgt = ST_RW;
      end
      ST_RW: begin
        adv       = 1'b1;
        spc       = drain;
        tgt       = ST_IDLE;
        rd_issue  = !r_wr;
        tbl_close = ap_mode;
        tbl_open  = !ap_mode;
      end
      ST_WAIT: begin
        if (cnt_zero) begin
          state_n = ret_q;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (adv) begin
      if (spc <= CNT_W'(1)) begin
        state_n = tgt;
      end else begin
        state_n  = ST_WAIT;
        ret_n    = tgt;
        cnt_load = 1'b1;
        cnt_val  = spc - CNT_W'(2);
      end
    end

    if (acc_q && state_n == ST_IDLE) begin
      done_n = 1'b1;
      acc_n  = 1'b0;
    end
  end

  assign ref_pend_n = refresh_req | (ref_pend_q & (state_q != ST_REF));

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q    <= ST_IDLE;
      ret_q      <= ST_IDLE;
      acc_q      <= 1'b0;
      done_q     <= 1'b0;
      ref_pend_q <= 1'b0;
    end else begin
      state_q    <= state_n;
      ret_q      <= ret_n;
      acc_q      <= acc_n;
      done_q     <= done_n;
      ref_pend_q <= ref_pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      r_bank  <= req_bank;
      r_row   <= req_row;
      r_col   <= req_col;
      r_be    <= req_be;
      r_wr    <= req_write;
      r_burst <= req_burst;
    end
  end

  // ---------------- output decode from registered state
  logic [3:0] cmd;

  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    sd_ba   = '0;
    unique case (state_q)
      ST_PREA: begin
        cmd             = CMD_PRE;
        sd_addr[AP_BIT] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_PRE: begin
        cmd   = CMD_PRE;
        sd_ba = r_bank;
      end
      ST_ACT: begin
        cmd     = CMD_ACT;
        sd_addr = r_row;
        sd_ba   = r_bank;
      end
      ST_RW: begin
        cmd                  = r_wr ? CMD_WRIT : CMD_READ;
        sd_addr[COL_W-1:0]   = r_col;
        sd_addr[AP_BIT]      = ap_mode;
        sd_ba                = r_bank;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dqm   = acc_q ? ~r_be : {BE_W{1'b1}};
  assign acc_done = done_q;

  // ---------------- assertions
  logic is_col_cmd;
  assign is_col_cmd = (cmd == CMD_READ) || (cmd == CMD_WRIT);

  // R2: auto-precharge bit follows the mode on every column command
  p_ap_bit_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    is_col_cmd |-> (sd_addr[AP_BIT] == !cfg_bank_active));

  // R3 / R7: row hit goes straight to the column command
  p_hit_direct_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && req_local && look_hit && !(!req_write && cl_one)) |=> is_col_cmd);

  // R6: CAS latency one row-hit read gets one NOP with the byte mask ahead of READ
  p_cl1_nop_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && req_local && look_hit && !req_write && cl_one)
      |=> (cmd == CMD_NOP && sd_dqm == ~$past(req_be)) ##1 (cmd == CMD_READ));

  // R9: a pending refresh in idle leads to precharge-all or refresh
  p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_IDLE && ref_pend_q) |=> (cmd == CMD_PRE || cmd == CMD_REF));

  // R10: other-region requests issue nothing and finish next cycle
  p_other_region_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && !req_local) |=> (cmd == CMD_NOP && acc_done));

  // R11: no column command while read data is returning
  p_no_cmd_in_data_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid |-> !is_col_cmd);

  // R12: done is only signalled from idle
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_done |-> (cmd == CMD_NOP && state_q == ST_IDLE));

endmodule

// File: tb/tb_sdram_row_seq.sv
`timescale 1ns/1ps
module tb_sdram_row_seq;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_ACT  = 4'b0011;
  localparam logic [3:0] C_READ = 4'b0101;
  localparam logic [3:0] C_WRIT = 4'b0100;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_local, req_write, req_burst;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [7:0]  req_col;
  logic [1:0]  req_be;
  logic refresh_req;
  logic cfg_bank_active;
  logic [1:0] cfg_cas_lat;
  logic [3:0] cfg_trcd, cfg_trp, cfg_trwl_tap, cfg_trfc;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;
  logic [1:0]  sd_ba;
  logic [1:0]  sd_dqm;
  logic acc_done, rd_valid;
  logic [3:0] cmd_w;

  always #4 clk = ~clk;

  sdram_row_seq dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_local(req_local),
    .req_write(req_write), .req_burst(req_burst), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_be(req_be),
    .refresh_req(refresh_req),
    .cfg_bank_active(cfg_bank_active), .cfg_cas_lat(cfg_cas_lat),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trwl_tap(cfg_trwl_tap),
    .cfg_trfc(cfg_trfc),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm),
    .acc_done(acc_done), .rd_valid(rd_valid)
  );

  assign cmd_w = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  bit m_open [4];
  int m_row  [4];
  int cl, trcd, trp, trwl, trfc;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input bit ba, input int c);
    cl   = c;
    trcd = c;
    trp  = 5 - c;
    trwl = c + 1;
    trfc = 2 + c;
    cfg_bank_active = ba;
    cfg_cas_lat     = 2'(cl);
    cfg_trcd        = 4'(trcd);
    cfg_trp         = 4'(trp);
    cfg_trwl_tap    = 4'(trwl);
    cfg_trfc        = 4'(trfc);
  endtask

  // Called at a falling edge with the sequencer idle.
  task automatic do_access(input int bank, input int row, input int col,
                           input bit wr, input bit burst, input int be);
    int kind, t_act, t_rw, beats, drain, t_done, bad_k, bad_a, bad_e;
    int rv_bad, dn_bad;
    bit ap;
    string tag;
    ap    = !cfg_bank_active;
    beats = burst ? BL : 1;
    if (m_open[bank] && m_row[bank] == row) kind = 1;
    else if (m_open[bank]) kind = 2;
    else kind = 0;
    t_act = -1;
    if (kind == 1) t_rw = (!wr && cl == 1) ? 2 : 1;
    else if (kind == 0) begin t_act = 1; t_rw = 1 + trcd; end
    else begin t_act = 1 + trp; t_rw = t_act + trcd; end
    if (wr) drain = beats + (ap ? trwl : 0);
    else    drain = cl + beats + (ap ? trp : 0);
    t_done = t_rw + drain;
    if (ap) tag = wr ? "R8" : "R5";
    else if (kind == 0) tag = "R5";
    else if (kind == 2) tag = "R4";
    else if (wr) tag = "R3";
    else tag = (cl == 1) ? "R6" : "R7";

    req_valid = 1'b1; req_local = 1'b1; req_write = wr; req_burst = burst;
    req_bank = 2'(bank); req_row = 12'(row); req_col = 8'(col); req_be = 2'(be);
    check(req_ready == 1'b1, "R12", "ready before access", int'(req_ready), 1);
    @(posedge clk);
    bad_k = -1; bad_a = 0; bad_e = 0; rv_bad = 0; dn_bad = 0;
    for (int k = 1; k <= t_done; k++) begin
      logic [3:0] exp_c;
      bit exp_rv;
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (k == t_rw) exp_c = wr ? C_WRIT : C_READ;
      else if (kind == 2 && k == 1) exp_c = C_PRE;
      else if (k == t_act) exp_c = C_ACT;
      else exp_c = C_NOP;
      if (cmd_w !== exp_c && bad_k < 0) begin
        bad_k = k; bad_a = int'(cmd_w); bad_e = int'(exp_c);
      end
      exp_rv = !wr && (k >= t_rw + cl) && (k < t_rw + cl + beats);
      if (rd_valid !== exp_rv) rv_bad++;
      if (acc_done !== (k == t_done)) dn_bad++;
      if (k == t_rw) begin
        check(sd_addr[10] == ap, "R2", "auto-precharge bit", int'(sd_addr[10]), int'(ap));
        check(sd_addr[7:0] == 8'(col) && sd_ba == 2'(bank), "R2", "column/bank",
              int'({sd_ba, sd_addr[7:0]}), (bank << 8) | col);
        check(sd_dqm == ~2'(be), tag, "dqm at column command", int'(sd_dqm), int'(~2'(be)));
      end
      if (k == t_act) begin
        check(sd_addr == 12'(row) && sd_ba == 2'(bank), "R5", "activate row/bank",
              int'(sd_addr), row);
      end
      if (kind == 2 && k == 1) begin
        check(sd_addr[10] == 1'b0 && sd_ba == 2'(bank), "R4", "single-bank precharge",
              int'({sd_ba, sd_addr[10]}), bank << 1);
      end
      if (kind == 1 && t_rw == 2 && k == 1) begin
        check(sd_dqm == ~2'(be), "R6", "dqm lead in NOP cycle", int'(sd_dqm), int'(~2'(be)));
      end
      if (k == t_done) begin
        check(req_ready == 1'b1 && sd_dqm == 2'b11, "R12", "ready and mask at done",
              int'({req_ready, sd_dqm}), 7);
      end
    end
    check(bad_k < 0, tag, $sformatf("command trace (first bad cycle %0d, exp %0d)", bad_k, bad_e),
          bad_a, bad_e);
    check(rv_bad == 0, "R11", "rd_valid mismatching cycles", rv_bad, 0);
    check(dn_bad == 0, "R12", "acc_done mismatching cycles", dn_bad, 0);
    if (ap) m_open[bank] = 0;
    else begin m_open[bank] = 1; m_row[bank] = row; end
  endtask

  task automatic do_refresh();
    bit any;
    int t_ref, bad_k, bad_a, bad_e;
    any = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    t_ref = any ? 2 + trp : 2;
    refresh_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    refresh_req = 1'b0;
    check(req_ready == 1'b0, "R9", "ready with refresh pending", int'(req_ready), 0);
    // a local request offered now must wait behind the refresh
    req_valid = 1'b1; req_local = 1'b1; req_write = 1'b0; req_bank = 2'd0;
    req_row = 12'd5; req_col = 8'd0; req_burst = 1'b0; req_be = 2'b11;
    bad_k = -1; bad_a = 0; bad_e = 0;
    for (int k = 2; k <= t_ref + trfc; k++) begin
      logic [3:0] exp_c;
      @(negedge clk);
      if (k == 2) req_valid = 1'b0;
      if (any && k == 2) begin
        exp_c = C_PRE;
        check(sd_addr[10] == 1'b1, "R9", "precharge-all address bit", int'(sd_addr[10]), 1);
      end else if (k == t_ref) exp_c = C_REF;
      else exp_c = C_NOP;
      if ((cmd_w !== exp_c || acc_done) && bad_k < 0) begin
        bad_k = k; bad_a = int'(cmd_w); bad_e = int'(exp_c);
      end
    end
    check(bad_k < 0, "R9", $sformatf("refresh trace (first bad cycle %0d)", bad_k), bad_a, bad_e);
    check(req_ready == 1'b1, "R9", "ready after refresh", int'(req_ready), 1);
    for (int b = 0; b < 4; b++) m_open[b] = 0;
  endtask

  task automatic do_other();
    req_valid = 1'b1; req_local = 1'b0; req_write = 1'b0; req_bank = 2'd1;
    req_row = 12'd999; req_col = 8'd3; req_burst = 1'b1; req_be = 2'b01;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(acc_done == 1'b1 && cmd_w == C_NOP, "R10", "other region done, no command",
          int'({acc_done, cmd_w}), int'({1'b1, C_NOP}));
    @(negedge clk);
    check(acc_done == 1'b0 && cmd_w == C_NOP, "R10", "no command after other region",
          int'({acc_done, cmd_w}), int'({1'b0, C_NOP}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_local = 0; req_write = 0; req_burst = 0;
    req_bank = 0; req_row = 0; req_col = 0; req_be = 0; refresh_req = 0;
    set_cfg(1'b0, 1);
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_w == C_NOP, "R1", "command after reset", int'(cmd_w), int'(C_NOP));
    check(!acc_done && !rd_valid, "R1", "done/valid after reset", int'({acc_done, rd_valid}), 0);
    check(req_ready && sd_dqm == 2'b11, "R1", "ready/mask after reset",
          int'({req_ready, sd_dqm}), 7);

    for (int mode = 0; mode < 2; mode++) begin
      for (int c = 1; c <= 3; c++) begin
        set_cfg(mode[0], c);
        do_refresh();
        for (int bank = 0; bank < 4; bank++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int bu = 0; bu < 2; bu++) begin
              int ra, rb, col;
              ra  = (bank * 37 + c * 5 + wr * 3 + bu) % 4096;
              rb  = ra + 100;
              col = (bank * 16 + wr * 4 + bu * 2 + c) % 256;
              do_access(bank, ra, col, wr[0], bu[0], (bank + wr + 1) % 4);
              do_access(bank, ra, col + 1, wr[0], bu[0], (bank + 2) % 4);
              do_access(bank, rb, col + 2, wr[0], bu[0], 3);
            end
          end
        end
        // R10: other-region request leaves open rows alone; next access still hits
        do_other();
        do_access(1, m_row[1], 7, 1'b0, 1'b1, 2);
        // R9: after refresh the bank is closed again
        do_refresh();
        do_access(1, m_row[1], 9, 1'b1, 1'b0, 1);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule